// File: doc/BRIEF.md
# RAM-Based Programmable Delay Line

This block delays a data stream by a number of clock cycles chosen at run time. The samples stay where they were first written in a small storage array. Only the addresses move. A write pointer steps through the array once per enabled cycle. The read address is the write pointer minus the selected delay, so the output taps the sample written that many enabled cycles earlier. A 6-bit select input picks any delay from 0 to 63 cycles. A delay of 0 passes the input straight through.

The block suits long delays where a chain of flip-flops would cost too much area and switching power. It also suits stream alignment where the required skew is only known at run time. A shift enable freezes the pointers and the output, so the delay line can stall together with the stream that feeds it.

Top module: `ptr_delay_line`

## Requirements
- R1: While reset is applied, and in every cycle after reset until the first enabled cycle, `dout` is 0.
- R2: For a selected delay d from 1 to 63, during an enabled cycle `dout` equals the `din` value written d enabled cycles earlier. Cycles with `shift_en` low are not counted.
- R3: With a selected delay of 0, during an enabled cycle `dout` equals `din` of that same cycle, with no clock edge in between.
- R4: `dly_sel` is sampled on every rising clock edge, whether or not `shift_en` is high. The value sampled governs `dout` from the cycle after that edge.
- R5: During an enabled cycle with a selected delay d of 1 or more, `dout` is 0 if fewer than d enabled cycles have occurred since reset.
- R6: In a cycle with `shift_en` low, nothing is written and the pointers do not move. `dout` keeps the value it had in the most recent enabled cycle, or 0 if there has been none since reset.
- R7: The write pointer wraps modulo 64 entries. Any delay stays exact over runs much longer than 64 enabled cycles, including the maximum delay of 63.
- R8: Changing the delay while data is flowing loses no stored history. After a change to a larger or smaller d, `dout` is the sample written d enabled cycles earlier, provided at least d enabled cycles have occurred since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| shift_en | input | 1 | High: write `din` and advance the pointers this cycle; low: stall |
| din | input | 8 | Sample entering the delay line |
| dly_sel | input | 6 | Requested delay in enabled cycles, 0 to 63 |
| dout | output | 8 | Delayed sample |

## Verification
The output is combinational from the current input, the stored samples and two registers: the sampled delay and the held output. Each result is therefore due in the cycle itself. A delay of 0 shows `din` at once. A delay of d shows the sample from d enabled cycles back. A new `dly_sel` value acts one edge after it is presented. A stall freezes `dout` starting in the stalled cycle. The bench drives inputs on the falling edge and compares `dout` one nanosecond later, before the next rising edge, against a queue of written samples and a delay variable. The delay variable is updated after each comparison, which mirrors the one-edge latency of the select input.

// File: rtl/dly_pkg.sv
package dly_pkg;

  // Source feeding the output port in the current cycle.
  typedef enum logic [1:0] {
    SRC_BYPASS = 2'd0,
    SRC_STORE  = 2'd1,
    SRC_ZERO   = 2'd2,
    SRC_HOLD   = 2'd3
  } dly_src_e;

endpackage

// File: rtl/dly_ptr.sv
module dly_ptr #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic [AW-1:0] dly_sel,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] dly_cur,
  output logic          hist_ok
);

  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic [AW-1:0] wr_q, wr_d;
  logic [AW-1:0] fill_q, fill_d;
  logic [AW-1:0] dly_q, dly_d;

  // Next-state logic.
  always_comb begin
    wr_d   = wr_q;
    fill_d = fill_q;
    dly_d  = dly_sel;
    if (shift_en) begin
      wr_d = wr_q + 1'b1;
      if (fill_q != LAST) fill_d = fill_q + 1'b1;
    end
  end

  // State registers. The write pointer starts at the last entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= LAST;
      fill_q <= '0;
      dly_q  <= '0;
    end else begin
      wr_q   <= wr_d;
      fill_q <= fill_d;
      dly_q  <= dly_d;
    end
  end

  assign wr_addr = wr_q;
  assign rd_addr = wr_q - dly_q;
  assign dly_cur = dly_q;
  assign hist_ok = (fill_q >= dly_q);

  // R7: the pointer steps by one per enabled cycle and wraps.
  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (wr_q == $past(wr_q) + 1'b1));

  // R6: the pointer holds in a stall.
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(wr_q));

  // R4: the delay select is taken on every edge.
  assert_dly_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dly_q == $past(dly_sel)));

  // R5: the fill count never decreases while reset is off.
  assert_fill_mono_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fill_q >= $past(fill_q)));

endmodule

// File: rtl/dly_store.sv
module dly_store #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] word_q [DEPTH];

  // One enabled register per entry; contents need no reset because
  // unwritten entries are masked by the history check.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    logic sel_w;
    assign sel_w = wr_en && (wr_addr == AW'(gi));
    always_ff @(posedge clk) begin
      if (sel_w) word_q[gi] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_addr];

endmodule

// File: rtl/dly_out.sv
module dly_out
  import dly_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] store_data,
  input  logic [AW-1:0] dly_cur,
  input  logic          hist_ok,
  output logic [DW-1:0] dout
);

  dly_src_e      src;
  logic [DW-1:0] hold_q, hold_d;

  always_comb begin
    if (!shift_en)          src = SRC_HOLD;
    else if (dly_cur == '0) src = SRC_BYPASS;
    else if (!hist_ok)      src = SRC_ZERO;
    else                    src = SRC_STORE;
  end

  always_comb begin
    unique case (src)
      SRC_BYPASS: dout = din;
      SRC_STORE:  dout = store_data;
      SRC_ZERO:   dout = '0;
      default:    dout = hold_q;
    endcase
  end

  always_comb begin
    hold_d = hold_q;
    if (shift_en) hold_d = dout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  // R3: zero delay passes the input through in the same cycle.
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && dly_cur == '0) |-> (dout == din));

  // R5: taps into unwritten history read as zero.
  assert_empty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && dly_cur != '0 && !hist_ok) |-> (dout == '0));

  // R6: consecutive stalled cycles keep the output steady.
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && $past(!shift_en)) |-> $stable(dout));

endmodule

// File: rtl/ptr_delay_line.sv
module ptr_delay_line #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] dly_sel,
  output logic [DW-1:0] dout
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [AW-1:0] wr_addr, rd_addr, dly_cur;
  logic          hist_ok;
  logic [DW-1:0] store_data;
  logic          en_int;

  // No writes or pointer motion while the block is held in reset.
  assign en_int = shift_en && rst_int_n;

  dly_ptr #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .shift_en (en_int),
    .dly_sel  (dly_sel),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .dly_cur  (dly_cur),
    .hist_ok  (hist_ok)
  );

  dly_store #(.DW(DW), .AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (en_int),
    .wr_addr (wr_addr),
    .wr_data (din),
    .rd_addr (rd_addr),
    .rd_data (store_data)
  );

  dly_out #(.DW(DW), .AW(AW)) u_out (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .shift_en   (en_int),
    .din        (din),
    .store_data (store_data),
    .dly_cur    (dly_cur),
    .hist_ok    (hist_ok),
    .dout       (dout)
  );

  // R1: the output is zero while reset is held.
  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_int_n |-> (dout == '0));

endmodule

// File: tb/test_ptr_delay_line.sv
`timescale 1ns/1ps
module test_ptr_delay_line;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       shift_en;
  logic [7:0] din;
  logic [5:0] dly_sel;
  logic [7:0] dout;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] hist[$];
  logic [7:0] held;
  int         dmod;

  always #2.5 clk = ~clk;

  ptr_delay_line i_ptr_delay_line (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .din(din), .dly_sel(dly_sel), .dout(dout)
  );

  task automatic model_reset();
    hist.delete();
    held = '0;
    dmod = 0;
  endtask

  // One clock: drive on the falling edge, compare, then advance the model.
  task automatic step(input bit en, input logic [7:0] d, input logic [5:0] sel,
                      input string tag);
    logic [7:0] exp;
    string      t;
    @(negedge clk);
    shift_en = en; din = d; dly_sel = sel;
    #1;
    if (!en)                   begin exp = held; t = "R6"; end
    else if (dmod == 0)        begin exp = d; t = "R3"; end
    else if (hist.size() < dmod) begin exp = '0; t = "R5"; end
    else                       begin exp = hist[dmod-1]; t = tag; end
    checks++;
    if (dout !== exp) begin
      failures++;
      $display("FAIL %s: dout=%h expected=%h (delay %0d)", t, dout, exp, dmod);
    end
    if (en) begin
      held = exp;
      hist.push_front(d);
      if (hist.size() > 64) void'(hist.pop_back());
    end
    dmod = sel;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; shift_en = 1'b0; din = '0; dly_sel = '0;
    model_reset();
    repeat (2) begin
      @(negedge clk); #1;
      checks++;
      if (dout !== 8'h00) begin
        failures++;
        $display("FAIL R1: dout=%h expected=00 in reset", dout);
      end
    end
    rst_n = 1'b1;
    // Stalled cycles while the internal reset releases (R1).
    repeat (4) step(1'b0, 8'hA5, 6'd0, "R1");
  endtask

  initial begin
    rst_n = 1'b0; shift_en = 1'b0; din = '0; dly_sel = '0;
    model_reset();
    do_reset();

    // R3: zero delay.
    for (int i = 0; i < 8; i++) step(1'b1, 8'($urandom), 6'd0, "R3");
    // R5 then R2: delay 10 with only 8 samples written at first.
    step(1'b1, 8'($urandom), 6'd10, "R4");
    for (int i = 0; i < 30; i++) step(1'b1, 8'($urandom), 6'd10, "R2");
    // R6: random stalls; select changes while stalled (R4).
    for (int i = 0; i < 60; i++)
      step(1'($urandom % 2), 8'($urandom), (i % 20 == 7) ? 6'd3 : 6'd10, "R2");
    // R8 and R4: delay changes while data flows.
    for (int i = 0; i < 200; i++)
      step(1'b1, 8'($urandom), (i % 9 == 0) ? 6'($urandom) : dly_sel, "R8");
    // R7: maximum delay over many wraps.
    for (int i = 0; i < 300; i++) step(1'b1, 8'($urandom), 6'd63, "R7");
    for (int i = 0; i < 100; i++)
      step(1'($urandom % 4 != 0), 8'($urandom), 6'd63, "R7");

    // Reset mid-run: history is discarded (R1, R5).
    do_reset();
    for (int i = 0; i < 80; i++) step(1'b1, 8'($urandom), 6'd40, "R2");
    for (int i = 0; i < 40; i++) step(1'b1, 8'($urandom), 6'd1, "R8");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule